// File: doc/BRIEF.md
# Loopback-Selectable Serial Datapath Core

This core sits between a 16-bit parallel interface and a one-bit serial line. On the transmit side it takes a parallel word, serializes it most significant bit first and drives the serial line output. On the receive side it shifts serial bits into 16-bit words and presents each finished word together with a one-cycle word strobe and a valid flag derived from signal detect. The recovered and synthesized bit clocks are represented by one clock plus two bit-rate strobes: `rx_bit_en` stands for the recovered clock and `tx_bit_en` for the synthesized one.

Four control inputs steer the serial data. An unretimed line loop copies the line input straight to the line output. A retimed facility loop copies it through one register clocked by the receive strobe, while the receiver keeps deserializing the line. A diagnostic loop feeds the transmit serial stream into the receiver in place of the line input, so that parallel transmit words come back on the receive word output. A loop-timing control makes the transmit shifter advance on the receive strobe. A main reset clears the datapath. A separate FIFO reset clears only a receive-word write pointer, which is the sole modeled part of the elastic buffer. An active-low power-down input freezes all activity.

Top module: `lb_serdes_core`

## Requirements
- R1: Each time the transmit shifter steps with its bit counter at 15, `tx_load` is high in that cycle and `tx_word` is captured at that edge. Bit 15 of the captured word is driven on the serial stream first, and bit 0 last. The first step after reset is a load.
- R2: The receiver places the first received bit of a word in bit 15 of `rx_word`. `rx_word_en` is high for exactly one cycle, in the cycle when the new word first appears, and a word completes every 16 receive steps. The first receive step after reset completes a word, so the next 16 steps form the first full word.
- R3: With `facility_loop` high and `raw_loop` low, `line_out` equals the `line_in` value captured at the previous receive step. The receiver still assembles words from `line_in`.
- R4: With `diag_loop` high, the receiver takes the transmit serial stream instead of `line_in`. When both strobes run every cycle, the transmitted words return on `rx_word` in order, after one leading all-zero word.
- R5: With `diag_loop` high, `sig_det` is ignored and every completed word carries `rx_valid` = 1.
- R6: With `raw_loop` high, `line_out` follows `line_in` in the same cycle with no register, even when `facility_loop` is also high.
- R7: With `loop_time` high, the transmit shifter steps on `rx_bit_en`; with it low, it steps on `tx_bit_en`.
- R8: Outside the diagnostic loop, `rx_valid` equals `sig_det` as sampled at the edge that completes the word. With no loop selected and `sig_det` low, words are flagged invalid.
- R9: `rst_n` low clears the datapath but leaves `fifo_wptr` unchanged. `fifo_rst_n` low clears only `fifo_wptr` and does not stop the receiver. `fifo_wptr` advances by one, modulo 16, per `rx_word_en` pulse.
- R10: With `pwr_dn_n` low, both shifters hold, `line_out` is 0 and no `rx_word_en` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous main reset |
| fifo_rst_n | input | 1 | Active-low asynchronous FIFO pointer reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| tx_bit_en | input | 1 | Transmit bit strobe |
| rx_bit_en | input | 1 | Receive bit strobe |
| facility_loop | input | 1 | Retimed line-to-line loop |
| diag_loop | input | 1 | Transmit-to-receive internal loop |
| raw_loop | input | 1 | Unretimed line-to-line loop |
| loop_time | input | 1 | Transmit shifter uses the receive strobe |
| sig_det | input | 1 | Line signal detect |
| tx_word | input | 16 | Parallel transmit word |
| tx_load | output | 1 | Word is captured at this edge |
| line_in | input | 1 | Serial line input |
| line_out | output | 1 | Serial line output |
| rx_word | output | 16 | Parallel receive word |
| rx_word_en | output | 1 | Word-rate strobe marking a new word |
| rx_valid | output | 1 | Validity of the current word |
| fifo_wptr | output | 4 | Receive-word write pointer |

## Verification
The assertions assume that both resets are applied asynchronously and released away from the clock edge. They also assume that the mode controls and `sig_det` change only between edges, so that a value read back one cycle later reflects what the core actually sampled. The stimulus changes every input either at a falling edge or just after a rising edge. It switches loop modes only while the main reset is held, except for `loop_time`, `sig_det` and the strobes, which it changes at points where the expected word boundaries are already fixed.

// File: rtl/lb_pkg.sv
package lb_pkg;

    localparam int unsigned LB_WORD_W = 16;
    localparam int unsigned LB_PTR_W  = 4;

    typedef enum logic [1:0] {
        SRC_TX      = 2'd0,
        SRC_RETIMED = 2'd1,
        SRC_RAW     = 2'd2,
        SRC_QUIET   = 2'd3
    } route_src_e;

endpackage

// File: rtl/lb_tx_ser.sv
module lb_tx_ser #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] word,
    output logic         load,
    output logic         ser
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (run && step) begin
            if (st_q.cnt == LAST) begin
                load     = 1'b1;
                st_d.sh  = word;
                st_d.cnt = '0;
            end else begin
                st_d.sh  = {st_q.sh[W-2:0], 1'b0};
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.cnt <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser = st_q.sh[W-1];

    AST_TX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && step) |=> $stable(ser)); // R7

    AST_TX_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load); // R1

endmodule

// File: rtl/lb_rx_des.sv
module lb_rx_des #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic         ser_in,
    input  logic         sig_ok,
    output logic [W-1:0] word,
    output logic         word_en,
    output logic         valid
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  des;
        logic [CW-1:0] cnt;
        logic [W-1:0]  word;
        logic          word_en;
        logic          valid;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.word_en = 1'b0;
        if (run && step) begin
            st_d.des = {st_q.des[W-2:0], ser_in};
            if (st_q.cnt == LAST) begin
                st_d.word    = {st_q.des[W-2:0], ser_in};
                st_d.word_en = 1'b1;
                st_d.valid   = sig_ok;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.des     <= '0;
            st_q.cnt     <= LAST;
            st_q.word    <= '0;
            st_q.word_en <= 1'b0;
            st_q.valid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word    = st_q.word;
    assign word_en = st_q.word_en;
    assign valid   = st_q.valid;

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_en |=> !word_en); // R2

    AST_RX_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_en |-> $stable(word)); // R2

endmodule

// File: rtl/lb_route.sv
module lb_route
    import lb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rx_step,
    input  logic facility,
    input  logic raw,
    input  logic diag,
    input  logic line_in,
    input  logic tx_ser,
    output logic line_out,
    output logic rx_src
);
    typedef struct packed {
        logic rt;
    } rt_st_t;

    rt_st_t     st_d, st_q;
    route_src_e src;

    always_comb begin
        st_d = st_q;
        if (run && rx_step) begin
            st_d.rt = line_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!run) begin
            src = SRC_QUIET;
        end else if (raw) begin
            src = SRC_RAW;
        end else if (facility) begin
            src = SRC_RETIMED;
        end else begin
            src = SRC_TX;
        end
        case (src)
            SRC_RAW:     line_out = line_in;
            SRC_RETIMED: line_out = st_q.rt;
            SRC_TX:      line_out = tx_ser;
            default:     line_out = 1'b0;
        endcase
        rx_src = diag ? tx_ser : line_in;
    end

    AST_RETIME: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && facility && !raw && run && $past(run && rx_step))
        |-> (line_out == $past(line_in))); // R3

endmodule

// File: rtl/lb_fifo_hook.sv
module lb_fifo_hook #(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          fifo_rst_n,
    input  logic          push,
    output logic [PW-1:0] wptr
);
    typedef struct packed {
        logic [PW-1:0] ptr;
    } fh_st_t;

    fh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.ptr = st_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge fifo_rst_n) begin
        if (!fifo_rst_n) begin
            st_q.ptr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr = st_q.ptr;

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!fifo_rst_n)
        !push |=> $stable(wptr)); // R9

endmodule

// File: rtl/lb_serdes_core.sv
module lb_serdes_core
    import lb_pkg::*;
#(
    parameter int unsigned W     = LB_WORD_W,
    parameter int unsigned PTR_W = LB_PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_rst_n,
    input  logic             pwr_dn_n,
    input  logic             tx_bit_en,
    input  logic             rx_bit_en,
    input  logic             facility_loop,
    input  logic             diag_loop,
    input  logic             raw_loop,
    input  logic             loop_time,
    input  logic             sig_det,
    input  logic [W-1:0]     tx_word,
    output logic             tx_load,
    input  logic             line_in,
    output logic             line_out,
    output logic [W-1:0]     rx_word,
    output logic             rx_word_en,
    output logic             rx_valid,
    output logic [PTR_W-1:0] fifo_wptr
);
    logic run;
    logic tx_step;
    logic tx_ser;
    logic rx_src;
    logic sig_ok;

    assign run     = pwr_dn_n;
    assign tx_step = loop_time ? rx_bit_en : tx_bit_en;
    assign sig_ok  = diag_loop | sig_det;

    lb_tx_ser #(.W(W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (tx_step),
        .word  (tx_word),
        .load  (tx_load),
        .ser   (tx_ser)
    );

    lb_route u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rx_step  (rx_bit_en),
        .facility (facility_loop),
        .raw      (raw_loop),
        .diag     (diag_loop),
        .line_in  (line_in),
        .tx_ser   (tx_ser),
        .line_out (line_out),
        .rx_src   (rx_src)
    );

    lb_rx_des #(.W(W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (rx_bit_en),
        .ser_in  (rx_src),
        .sig_ok  (sig_ok),
        .word    (rx_word),
        .word_en (rx_word_en),
        .valid   (rx_valid)
    );

    lb_fifo_hook #(.PW(PTR_W)) u_fifo (
        .clk        (clk),
        .fifo_rst_n (fifo_rst_n),
        .push       (rx_word_en),
        .wptr       (fifo_wptr)
    );

    AST_DIAG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_en && $past(diag_loop)) |-> rx_valid); // R5

    AST_NOLOOP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_en && $past(!diag_loop && !sig_det)) |-> !rx_valid); // R8

    AST_PD_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pwr_dn_n) |-> !rx_word_en); // R10

endmodule

// File: tb/sim_lb_serdes_core.sv
module sim_lb_serdes_core;
    localparam int CLK_P = 10;
    localparam int NW    = 4;

    logic        clk = 1'b0;
    logic        rst_n, fifo_rst_n, pwr_dn_n;
    logic        tx_bit_en, rx_bit_en;
    logic        facility_loop, diag_loop, raw_loop, loop_time, sig_det;
    logic [15:0] tx_word;
    logic        tx_load;
    logic        line_in, line_out;
    logic [15:0] rx_word;
    logic        rx_word_en, rx_valid;
    logic [3:0]  fifo_wptr;

    typedef struct {
        logic [15:0] w;
        logic        v;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    fifo_cnt = 0;
    bit    sb_on = 0;
    bit    feed_on = 0;
    bit    feed_nxt = 0;
    int    feed_idx = 0;
    string cur_req = "R2";
    string cur_vreq = "R8";
    logic  prev_bit = 1'b0;
    logic [15:0] diag_w [NW];

    always #(CLK_P / 2) clk = ~clk;

    lb_serdes_core u0 (
        .clk(clk), .rst_n(rst_n), .fifo_rst_n(fifo_rst_n), .pwr_dn_n(pwr_dn_n),
        .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en),
        .facility_loop(facility_loop), .diag_loop(diag_loop),
        .raw_loop(raw_loop), .loop_time(loop_time), .sig_det(sig_det),
        .tx_word(tx_word), .tx_load(tx_load), .line_in(line_in),
        .line_out(line_out), .rx_word(rx_word), .rx_word_en(rx_word_en),
        .rx_valid(rx_valid), .fifo_wptr(fifo_wptr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] w, input logic v);
        exp_t e;
        e.w = w;
        e.v = v;
        exp_q.push_back(e);
    endtask

    // Monitor: scoreboard compare and independent word count for the pointer
    always @(negedge clk) begin
        if (!fifo_rst_n) begin
            fifo_cnt = 0;
        end else if (rx_word_en) begin
            fifo_cnt = fifo_cnt + 1;
        end
        if (rx_word_en && sb_on) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected word", 32'(rx_word), 32'(0));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rx_word == e.w, cur_req, "rx_word", 32'(rx_word), 32'(e.w));
                chk(rx_valid == e.v, cur_vreq, "rx_valid", 32'(rx_valid), 32'(e.v));
            end
        end
    end

    // Transmit feeder for the diagnostic loop (R4): expected item per load
    always @(negedge clk) begin
        if (feed_on) begin
            if (tx_load && feed_idx < NW) begin
                push_exp(tx_word, 1'b1);
                feed_idx = feed_idx + 1;
                feed_nxt = 1;
            end else if (feed_nxt) begin
                if (feed_idx < NW) tx_word = diag_w[feed_idx];
                feed_nxt = 0;
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(fifo_wptr == 4'(fifo_cnt), "R9", "wptr kept in main reset",
            32'(fifo_wptr), 32'(fifo_cnt % 16));
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic send_word(input logic [15:0] w, input bit chk_rt,
                             input bit chk_raw, input logic sd);
        for (int b = 15; b >= 0; b--) begin
            @(negedge clk);
            if (chk_rt)
                chk(line_out == prev_bit, "R3", "retimed line_out",
                    32'(line_out), 32'(prev_bit));
            line_in  = w[b];
            prev_bit = w[b];
            if (b == 15) sig_det = sd;
            if (chk_raw) begin
                #1;
                chk(line_out == w[b], "R6", "raw line_out", 32'(line_out), 32'(w[b]));
            end
        end
    endtask

    task automatic count_loads(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_load) cnt++;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int bad_we;
        int bad_lo;
        diag_w[0] = 16'hA5C3;
        diag_w[1] = 16'h8001;
        diag_w[2] = 16'hFFFF;
        diag_w[3] = 16'h1234;
        rst_n = 1'b0; fifo_rst_n = 1'b0; pwr_dn_n = 1'b1;
        tx_bit_en = 1'b1; rx_bit_en = 1'b1;
        facility_loop = 1'b0; diag_loop = 1'b0; raw_loop = 1'b0; loop_time = 1'b0;
        sig_det = 1'b0; tx_word = 16'h0000; line_in = 1'b0;

        // Reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rx_word_en == 1'b0, "R2", "reset word_en", 32'(rx_word_en), 32'(0));
        chk(rx_word == 16'h0, "R9", "reset rx_word", 32'(rx_word), 32'(0));
        chk(fifo_wptr == 4'h0, "R9", "reset wptr", 32'(fifo_wptr), 32'(0));
        @(posedge clk); #1;
        fifo_rst_n = 1'b1;

        // R1: serialization order
        tx_word = 16'hB38E;
        do_reset();
        @(negedge clk);
        chk(tx_load == 1'b1, "R1", "first step loads", 32'(tx_load), 32'(1));
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(line_out == tx_word[15-k], "R1", "serial bit", 32'(line_out),
                32'(tx_word[15-k]));
        end

        // R3: facility loop, retimed and deserialized
        facility_loop = 1'b1; sig_det = 1'b1; line_in = 1'b0;
        do_reset();
        cur_req = "R3"; cur_vreq = "R8";
        push_exp(16'h0000, 1'b1);
        push_exp(16'hC0DE, 1'b1);
        push_exp(16'h0F0F, 1'b1);
        sb_on = 1; prev_bit = 1'b0;
        @(negedge clk);
        send_word(16'hC0DE, 1, 0, 1'b1);
        send_word(16'h0F0F, 1, 0, 1'b1);
        wait (exp_q.size() == 0);
        sb_on = 0; facility_loop = 1'b0;

        // R8 / R2: no loop, validity follows signal detect
        sig_det = 1'b0; line_in = 1'b0;
        do_reset();
        cur_req = "R2"; cur_vreq = "R8";
        push_exp(16'h0000, 1'b0);
        push_exp(16'h7E81, 1'b0);
        push_exp(16'h5AA5, 1'b1);
        sb_on = 1;
        @(negedge clk);
        send_word(16'h7E81, 0, 0, 1'b0);
        send_word(16'h5AA5, 0, 0, 1'b1);
        wait (exp_q.size() == 0);
        sb_on = 0;

        // R4 / R5: diagnostic loop, line input replaced, detect ignored
        diag_loop = 1'b1; sig_det = 1'b0; line_in = 1'b1; tx_word = diag_w[0];
        feed_idx = 0; feed_nxt = 0;
        do_reset();
        cur_req = "R4"; cur_vreq = "R5";
        push_exp(16'h0000, 1'b1);
        sb_on = 1; feed_on = 1;
        wait (feed_idx == NW);
        wait (exp_q.size() == 0);
        sb_on = 0; feed_on = 0; diag_loop = 1'b0; line_in = 1'b0;

        // R6: unretimed loop wins over facility loop
        raw_loop = 1'b1; facility_loop = 1'b1;
        do_reset();
        @(negedge clk);
        send_word(16'h9C35, 0, 1, 1'b1);
        send_word(16'h36C9, 0, 1, 1'b1);
        raw_loop = 1'b0; facility_loop = 1'b0; line_in = 1'b0;

        // R7: loop timing selects the shifter strobe
        tx_bit_en = 1'b0; rx_bit_en = 1'b1; loop_time = 1'b0;
        do_reset();
        count_loads(32, n);
        chk(n == 0, "R7", "loads on stopped tx strobe", 32'(n), 32'(0));
        @(posedge clk); #1;
        loop_time = 1'b1;
        count_loads(32, n);
        chk(n == 2, "R7", "loads on rx strobe", 32'(n), 32'(2));
        @(posedge clk); #1;
        rx_bit_en = 1'b0; tx_bit_en = 1'b1;
        count_loads(32, n);
        chk(n == 0, "R7", "tx strobe ignored", 32'(n), 32'(0));
        @(posedge clk); #1;
        rx_bit_en = 1'b1; loop_time = 1'b0;

        // R10: power down freezes activity
        sig_det = 1'b1; tx_word = 16'hFFFF;
        do_reset();
        repeat (20) @(posedge clk);
        #1;
        pwr_dn_n = 1'b0;
        @(posedge clk);
        bad_we = 0; bad_lo = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rx_word_en) bad_we++;
            if (line_out) bad_lo++;
        end
        chk(bad_we == 0, "R10", "word strobes in power down", 32'(bad_we), 32'(0));
        chk(bad_lo == 0, "R10", "line_out high in power down", 32'(bad_lo), 32'(0));
        @(posedge clk); #1;
        pwr_dn_n = 1'b1;

        // R9: FIFO-only reset
        repeat (20) @(posedge clk);
        #1;
        fifo_rst_n = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rx_word_en) n++;
        end
        chk(fifo_wptr == 4'h0, "R9", "wptr in fifo reset", 32'(fifo_wptr), 32'(0));
        chk(n > 0, "R9", "receiver runs in fifo reset", 32'(n), 32'(1));
        @(posedge clk); #1;
        fifo_rst_n = 1'b1;
        repeat (40) @(posedge clk);
        do_reset();
        repeat (4) @(posedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule